// File: doc/BRIEF.md
# Command Packet Decoder and Serial Shifter

This block sits on the front-end interface side of a readout link. It takes a stream of 32-bit packet words, with one header word followed by zero or more data words. It decodes the header and carries out one of six commands. Depending on the command, it shifts a chip command and its data out serially to a front-end chip while capturing the chip's answer. It can also pulse a soft or a hard reset, fire a test pulse with a programmed amplitude, report the most recent sync status, or read and write a small control register of its own.

Replies leave on a second word stream as packets. A reply header carries the routing bits copied from the request and a word count equal to the number of reply data words that follow it. Both streams use a valid/ready handshake. The serial side uses a clock that the block generates, one data output and one data input.

Top module: `pkt_cmd_engine`

## Requirements
- R1: The header word is decoded as count = bits 31..24, field = bits 23..12, command = bits 11..8 and route = bits 1..0. Every reply header holds the request's route in bits 1..0, zeros in bits 7..2, the command code in bits 11..8, and in bits 31..24 the number of reply data words that follow it.
- R2: Command 0 shifts bits serially. In the first data word, bits 31..19 (the chip command) go out most-significant first. After them come bits 0..18 of that word, and then bits 0..31 of each later word, all least-significant first. Each bit takes two clocks: ser_clk is low for one clock with ser_dout already valid, then high for one clock. ser_din is sampled at the clock edge that ends the high phase.
- R3: For command 0, exactly min(field, 32 x count) bits are shifted. Data bits beyond the field count are discarded. Words that lie wholly beyond the count still produce a reply word, and that word is zero.
- R4: The command 0 reply is a header with count = request count and field = request field, followed by one data word per request word. In each reply word, a shifted chip-command bit echoes its outgoing value, a shifted data bit holds the sampled ser_din in the same bit position, and a bit that was not shifted is zero.
- R5: Command 1 asserts soft_rst for exactly PULSE_LEN clocks.
- R6: Command 4 asserts hard_rst for exactly PULSE_LEN clocks and clears both the control register and tp_amp to zero.
- R7: Command 2 replies with a header only (count 0). Bits 21..12 of that header hold sync_status as latched when the request header was accepted, and bits 23..22 are zero.
- R8: Command 3 loads tp_amp from request bits 17..12 and asserts tp_strobe for exactly PULSE_LEN clocks. tp_amp holds its value until the next command 3 or command 4.
- R9: Command 5 with count ≥ 1 writes the first data word into the control register, and any further words are consumed unused. With count 0 the register is only read. In both cases the reply is a header with count 1 and field 0, followed by the register value after any write.
- R10: Command codes 6 to 15 consume their data words and produce no reply, no serial activity and no strobe, and they leave the control register unchanged.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R12: After reset, in_ready is 1, and out_valid, ser_clk, soft_rst, hard_rst, tp_strobe and tp_amp are all 0.
- R13: A new header is not accepted while any strobe is active (in_ready is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request word valid |
| in_data | input | 32 | Request word |
| in_ready | output | 1 | Request word accepted when high with in_valid |
| out_valid | output | 1 | Reply word valid |
| out_data | output | 32 | Reply word |
| out_ready | input | 1 | Reply sink ready |
| ser_clk | output | 1 | Serial clock to the chip |
| ser_dout | output | 1 | Serial data to the chip |
| ser_din | input | 1 | Serial data from the chip |
| sync_status | input | 10 | Current sync status from the chip |
| soft_rst | output | 1 | Soft reset strobe |
| hard_rst | output | 1 | Hard reset strobe |
| tp_strobe | output | 1 | Test pulse strobe |
| tp_amp | output | 6 | Test pulse amplitude |

## Verification
The bench builds the block with PULSE_LEN = 4. At that value every strobe fits well within one packet gap, which lets the bench measure the exact pulse width and observe the header stall that each strobe causes. Packets carry up to four data words and shift counts from 0 to 159. This range covers counts inside the 13-bit command region, counts that end in the middle of a word, counts of zero, and counts beyond 32 times the word count. Random backpressure on out_ready holds replies over many cycles.

// File: rtl/pkt_cmd_engine.sv
module pkt_cmd_engine #(
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  output logic        ser_clk,
  output logic        ser_dout,
  input  logic        ser_din,
  input  logic [9:0]  sync_status,
  output logic        soft_rst,
  output logic        hard_rst,
  output logic        tp_strobe,
  output logic [5:0]  tp_amp
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  typedef enum logic [2:0] {S_HDR, S_RHDR, S_WORD, S_SHIFT, S_RWORD, S_RCSR} st_t;

  st_t         st;
  logic [7:0]  h_cnt, wleft;
  logic [11:0] h_fld, bleft;
  logic [3:0]  h_cmd;
  logic [1:0]  h_rt;
  logic [9:0]  sync_q;
  logic        first_w, ph;
  logic [4:0]  bidx;
  logic [31:0] sword, rword, csr;
  logic [CW-1:0] cnt_s, cnt_h, cnt_t;

  wire       strobing = soft_rst | hard_rst | tp_strobe;
  wire       in_cmd   = first_w && (bidx < 5'd13);
  wire [4:0] pos      = !first_w ? bidx : (in_cmd ? 5'd31 - bidx : bidx - 5'd13);

  assign soft_rst  = cnt_s != '0;
  assign hard_rst  = cnt_h != '0;
  assign tp_strobe = cnt_t != '0;
  assign in_ready  = (st == S_HDR && !strobing) || st == S_WORD;
  assign out_valid = st == S_RHDR || st == S_RWORD || st == S_RCSR;
  assign ser_clk   = st == S_SHIFT && ph;
  assign ser_dout  = st == S_SHIFT && sword[pos];

  always_comb begin
    case (st)
      S_RHDR:
        case (h_cmd)
          4'd0:    out_data = {h_cnt, h_fld, 4'd0, 6'd0, h_rt};
          4'd2:    out_data = {8'd0, 2'd0, sync_q, 4'd2, 6'd0, h_rt};
          default: out_data = {8'd1, 12'd0, 4'd5, 6'd0, h_rt};
        endcase
      S_RWORD: out_data = rword;
      S_RCSR:  out_data = csr;
      default: out_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HDR;
      h_cnt <= '0; h_fld <= '0; h_cmd <= '0; h_rt <= '0;
      wleft <= '0; bleft <= '0; sync_q <= '0;
      first_w <= 1'b0; ph <= 1'b0; bidx <= '0;
      sword <= '0; rword <= '0; csr <= '0; tp_amp <= '0;
      cnt_s <= '0; cnt_h <= '0; cnt_t <= '0;
    end else begin
      if (soft_rst)  cnt_s <= cnt_s - 1'b1;
      if (hard_rst)  cnt_h <= cnt_h - 1'b1;
      if (tp_strobe) cnt_t <= cnt_t - 1'b1;
      case (st)
        S_HDR: if (in_valid && in_ready) begin
          h_cnt   <= in_data[31:24];
          wleft   <= in_data[31:24];
          h_fld   <= in_data[23:12];
          bleft   <= in_data[23:12];
          h_cmd   <= in_data[11:8];
          h_rt    <= in_data[1:0];
          sync_q  <= sync_status;
          first_w <= 1'b1;
          case (in_data[11:8])
            4'd0, 4'd2: st <= S_RHDR;
            4'd5: st <= (in_data[31:24] != '0) ? S_WORD : S_RHDR;
            default: begin
              st <= (in_data[31:24] != '0) ? S_WORD : S_HDR;
              if (in_data[11:8] == 4'd1) cnt_s <= CW'(PULSE_LEN);
              if (in_data[11:8] == 4'd3) begin
                cnt_t  <= CW'(PULSE_LEN);
                tp_amp <= in_data[17:12];
              end
              if (in_data[11:8] == 4'd4) begin
                cnt_h  <= CW'(PULSE_LEN);
                csr    <= '0;
                tp_amp <= '0;
              end
            end
          endcase
        end
        S_RHDR: if (out_ready) begin
          if (h_cmd == 4'd5) st <= S_RCSR;
          else st <= (wleft != '0) ? S_WORD : S_HDR;
        end
        S_WORD: if (in_valid) begin
          wleft <= wleft - 1'b1;
          if (h_cmd == 4'd0) begin
            sword <= in_data;
            rword <= '0;
            bidx  <= '0;
            ph    <= 1'b0;
            st    <= (bleft != '0) ? S_SHIFT : S_RWORD;
          end else begin
            if (h_cmd == 4'd5 && first_w) csr <= in_data;
            first_w <= 1'b0;
            if (wleft == 8'd1) st <= (h_cmd == 4'd5) ? S_RHDR : S_HDR;
          end
        end
        S_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            rword[pos] <= in_cmd ? sword[pos] : ser_din;
            bidx  <= bidx + 1'b1;
            bleft <= bleft - 1'b1;
            if (bidx == 5'd31 || bleft == 12'd1) st <= S_RWORD;
          end
        end
        S_RWORD: if (out_ready) begin
          first_w <= 1'b0;
          st <= (wleft != '0) ? S_WORD : S_HDR;
        end
        S_RCSR: if (out_ready) st <= S_HDR;
        default: st <= S_HDR;
      endcase
    end
  end

  logic [CW-1:0] run_s, run_h, run_t;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s <= '0; run_h <= '0; run_t <= '0;
    end else begin
      run_s <= soft_rst  ? run_s + 1'b1 : '0;
      run_h <= hard_rst  ? run_h + 1'b1 : '0;
      run_t <= tp_strobe ? run_t + 1'b1 : '0;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r2_ser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !in_ready && !out_valid);
  a_r5_soft_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> run_s == CW'(PULSE_LEN));
  a_r6_hard_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hard_rst) |-> run_h == CW'(PULSE_LEN));
  a_r8_tp_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tp_strobe) |-> run_t == CW'(PULSE_LEN));
  a_r8_amp_steady: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe && $past(tp_strobe) |-> $stable(tp_amp));
  a_r13_no_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || hard_rst || tp_strobe) && in_ready |=> !$rose(out_valid) || $past(st) != S_HDR);

endmodule

// File: tb/pkt_cmd_engine_test.sv
module pkt_cmd_engine_test;
  localparam int PL = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, ser_din = 0;
  logic [31:0] in_data = '0;
  logic [9:0] sync_status = '0;
  logic in_ready, out_valid, ser_clk, ser_dout, soft_rst, hard_rst, tp_strobe;
  logic [31:0] out_data;
  logic [5:0] tp_amp;

  pkt_cmd_engine #(.PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din), .sync_status(sync_status),
    .soft_rst(soft_rst), .hard_rst(hard_rst), .tp_strobe(tp_strobe), .tp_amp(tp_amp));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] got_q[$];
  bit dout_q[$];
  bit resp_bits[1024];
  int ser_idx = 0;
  int n_pul[3], last_len[3], prun[3];
  logic [5:0] amp_seen;
  logic [31:0] pw[16];
  logic [31:0] csr_m = '0;
  logic [5:0] amp_m = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge ser_clk) begin
    dout_q.push_back(ser_dout);
    ser_din = resp_bits[ser_idx % 1024];
    ser_idx++;
  end

  always @(posedge clk) begin
    #1 out_ready <= ($urandom % 4) != 0;
  end

  always @(negedge clk) begin
    if (out_valid && out_ready) got_q.push_back(out_data);
    for (int i = 0; i < 3; i++) begin
      logic s;
      s = (i == 0) ? soft_rst : (i == 1) ? hard_rst : tp_strobe;
      if (s) begin
        if (i == 2 && prun[2] == 0) amp_seen = tp_amp;
        prun[i]++;
      end else if (prun[i] != 0) begin
        n_pul[i]++;
        last_len[i] = prun[i];
        prun[i] = 0;
      end
    end
  end

  task automatic send(input logic [31:0] hdr, input int nw);
    @(negedge clk);
    in_valid = 1; in_data = hdr;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < nw; i++) begin
      in_data = pw[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (in_ready && !out_valid) quiet++; else quiet = 0;
    end
  endtask

  task automatic run_pkt(input logic [31:0] hdr, input int nw);
    logic [31:0] exp_q[$];
    bit exp_b[$];
    int ep[3];
    int sh, n, mism;
    logic [4:0] pos;
    logic [31:0] rw;
    logic [3:0] cmd;
    logic [1:0] rt;
    string tg;
    string ptag[3];
    ptag[0] = "R5"; ptag[1] = "R6"; ptag[2] = "R8";
    cmd = hdr[11:8]; rt = hdr[1:0]; n = int'(hdr[23:12]);
    got_q.delete(); dout_q.delete(); ser_idx = 0;
    for (int i = 0; i < 3; i++) begin n_pul[i] = 0; ep[i] = 0; end
    sync_status = 10'($urandom);
    tg = (cmd == 0) ? "R1 R4 R11" : (cmd == 2) ? "R1 R7" : (cmd == 5) ? "R1 R9" :
         (cmd > 5) ? "R10" : "R1";
    case (cmd)
      4'd0: begin
        exp_q.push_back({8'(nw), hdr[23:12], 4'd0, 6'd0, rt});
        sh = 0;
        for (int w = 0; w < nw; w++) begin
          rw = '0;
          for (int b = 0; b < 32; b++) begin
            if (sh == n) break;
            if (w == 0) pos = (b < 13) ? 5'(31 - b) : 5'(b - 13); else pos = 5'(b);
            exp_b.push_back(pw[w][pos]);
            rw[pos] = (w == 0 && b < 13) ? pw[w][pos] : resp_bits[sh];
            sh++;
          end
          exp_q.push_back(rw);
        end
      end
      4'd1: ep[0] = 1;
      4'd2: exp_q.push_back({8'd0, 2'd0, sync_status, 4'd2, 6'd0, rt});
      4'd3: begin ep[2] = 1; amp_m = hdr[17:12]; end
      4'd4: begin ep[1] = 1; csr_m = '0; amp_m = '0; end
      4'd5: begin
        if (nw > 0) csr_m = pw[0];
        exp_q.push_back({8'd1, 12'd0, 4'd5, 6'd0, rt});
        exp_q.push_back(csr_m);
      end
      default: ;
    endcase
    send(hdr, nw);
    if ((cmd == 1 || cmd == 3 || cmd == 4) && nw == 0)
      check(!in_ready, "R13", "in_ready during strobe", 32'(in_ready), 0);
    wait_idle();
    check(got_q.size() == exp_q.size(), tg, "reply word count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] === exp_q[i], tg, $sformatf("reply word %0d", i), got_q[i], exp_q[i]);
    check(dout_q.size() == exp_b.size(), (cmd > 5) ? "R10" : "R3", "bits shifted",
          dout_q.size(), exp_b.size());
    mism = 0;
    for (int i = 0; i < exp_b.size() && i < dout_q.size(); i++)
      if (dout_q[i] != exp_b[i]) mism++;
    check(mism == 0, "R2", "serial bit order mismatches", mism, 0);
    for (int i = 0; i < 3; i++) begin
      check(n_pul[i] == ep[i], (cmd > 5) ? "R10" : ptag[i], "pulse count", n_pul[i], ep[i]);
      if (ep[i] != 0 && n_pul[i] != 0)
        check(last_len[i] == PL, ptag[i], "pulse width", last_len[i], PL);
    end
    if (cmd == 3) check(amp_seen == hdr[17:12], "R8", "amplitude at strobe", amp_seen, hdr[17:12]);
    check(tp_amp == amp_m, "R6 R8", "tp_amp held", tp_amp, amp_m);
  endtask

  function automatic logic [31:0] mkhdr(int cnt, int fld, int cmd, int rt);
    return {8'(cnt), 12'(fld), 4'(cmd), 6'($urandom), 2'(rt)};
  endfunction

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) resp_bits[i] = 1'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(in_ready && !out_valid && !ser_clk, "R12", "handshake idle", {in_ready, out_valid, ser_clk}, 3'b100);
    check(!soft_rst && !hard_rst && !tp_strobe && tp_amp == 0, "R12", "strobes idle",
          {soft_rst, hard_rst, tp_strobe, tp_amp}, 0);

    for (int i = 0; i < 16; i++) pw[i] = $urandom;
    run_pkt(mkhdr(1, 13, 0, 1), 1);     // R2 command bits only
    run_pkt(mkhdr(2, 45, 0, 2), 2);     // R3 ends mid second word
    run_pkt(mkhdr(2, 0, 0, 3), 2);      // R3 zero count
    run_pkt(mkhdr(1, 200, 0, 1), 1);    // R3 count past available bits
    run_pkt(mkhdr(0, 7, 0, 2), 0);      // R1 header only
    run_pkt(mkhdr(2, 0, 5, 1), 2);      // R9 write, extra word consumed
    run_pkt(mkhdr(0, 0, 5, 2), 0);      // R9 read back
    for (int i = 0; i < 16; i++) pw[i] = $urandom;
    run_pkt(mkhdr(3, 0, 9, 1), 3);      // R10 unknown consumes words
    run_pkt(mkhdr(0, 0, 5, 1), 0);      // R10 register untouched
    run_pkt(mkhdr(0, 12'h02A, 3, 2), 0); // R8
    run_pkt(mkhdr(0, 0, 1, 1), 0);      // R5
    run_pkt(mkhdr(0, 0, 2, 3), 0);      // R7
    run_pkt(mkhdr(0, 0, 4, 1), 0);      // R6 clears register and amplitude
    run_pkt(mkhdr(0, 0, 5, 2), 0);      // R6 read back

    for (int k = 0; k < 150; k++) begin
      int cmd, nw, n;
      cmd = ($urandom % 5 == 0) ? int'($urandom % 16) : int'($urandom % 6);
      nw = (cmd == 0) ? int'($urandom % 5) : int'($urandom % 3);
      n = int'($urandom % 160);
      for (int i = 0; i < 16; i++) pw[i] = $urandom;
      run_pkt(mkhdr(nw, n, cmd, 1 + int'($urandom % 2)), nw);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule